// File: doc/BRIEF.md
# PHY Management Register File

This block is the register store that sits behind the serial management port of a 10/100 Ethernet transceiver. A management front end, which is not part of this block, turns serial frames into a parallel access. The access has a 5-bit register address, a write strobe with 16 bits of write data, and a read strobe. The data for a read comes back on the register output one clock after the read strobe.

The block keeps the control word and drives its fields to the datapath. It also holds the two advertisement words that go out during negotiation. It returns the fixed identity and capability words. Status arriving from the datapath is folded into the readable words with the sticky behaviour that management software expects:
- a link indication that latches low;
- jabber and remote-fault indications that latch high;
- a page-received flag that clears on read.

Each sticky bit clears only when its own register is read. Copies of these bits in the summary status word are never cleared by reading the summary word.

Top module: `phy_mgmt_regs`

## Requirements
- R1: After hardware reset, the control word (address 0) equals {0, 0, strap_speed100, strap_an_en, 0, 0, 0, strap_full_duplex, 8'h00}. The advertisement word (address 4) reads 0x01E1. The next-page word (address 7) reads 0x2001 with bit 11 added as the inverse of tog_prev. Read data appears on rd_data on the clock after rd_en and holds until the next read.
- R2: The fixed and status words read as follows, and writes to them have no effect:
  - Address 2 reads 0x2000.
  - Address 3 reads 0x5CA2.
  - Address 1 reads 0x7849, with bit 5 set to an_done, bit 4 to the remote-fault latch, bit 2 to the link latch and bit 1 to the jabber latch.
  - Address 5 reads lp_ability.
  - Address 6 reads {13'b0, 1'b1, page latch, lp_an_able}.
  - Address 16 reads the following bits, with all other bits 0: bit 8 page latch, bit 6 remote-fault latch, bit 5 jabber latch, bit 4 an_done, bit 3 loopback, bit 2 full_dup, bit 1 spd10, bit 0 link latch.
  - Every other address reads 0x0000.
- R3: Reserved bits ignore writes and read as 0. The writable mask is 0xADFF at address 4 and 0xB7FF at address 7. Bit 11 of address 7 always reads as ~tog_prev.
- R4: Writing 1 to control bit 15 sets it. It then reads 1 and drives ctl_sw_reset until reset_done is seen. At that point the control and advertisement words return to their reset values and all latches clear.
- R5: Control bit 9 (restart) is set only by a write that has both bit 9 and bit 12 set. A later write of 0 does not clear it. It clears on an_started. It drives ctl_an_restart.
- R6: The power-down bit (control bit 11) reads and drives ctl_pdown as the stored bit ORed with !pwrdn_n. A low pwrdn_n also sets the stored bit, so it stays set after the pin returns high.
- R7: The link latch falls whenever link_ok is low. It rises only on a read of address 1 while link_ok is high.
- R8: The jabber and remote-fault latches set on their event inputs. They clear only on a read of address 1. Reading address 16 leaves them set.
- R9: The page latch sets on page_rx_evt and clears only on a read of address 6. Reading address 16 leaves it set.
- R10: A read returns the value held before that read clears anything. An event in the same cycle as a clearing read leaves the latch set.
- R11: ctl_force_spd100 and ctl_force_fdx equal control bits 13 and 8 while control bit 12 is 0. They are 0 while bit 12 is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| strap_an_en | input | 1 | Reset value of negotiation enable |
| strap_speed100 | input | 1 | Reset value of forced speed bit |
| strap_full_duplex | input | 1 | Reset value of forced duplex bit |
| pwrdn_n | input | 1 | Active-low power-down pin |
| reg_addr | input | 5 | Register address |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 16 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 16 | Read data, valid one clock after rd_en |
| link_ok | input | 1 | Link good level from datapath |
| jabber_evt | input | 1 | Jabber event |
| rfault_evt | input | 1 | Remote-fault event |
| an_done | input | 1 | Negotiation complete |
| page_rx_evt | input | 1 | Link code word received |
| spd10 | input | 1 | Resolved speed, 1 = 10 Mb/s |
| full_dup | input | 1 | Resolved duplex, 1 = full |
| lp_an_able | input | 1 | Link partner can negotiate |
| lp_ability | input | 16 | Link partner ability word |
| tog_prev | input | 1 | Toggle of previously exchanged page |
| reset_done | input | 1 | Software reset process finished |
| an_started | input | 1 | Negotiation restart initiated |
| ctl_sw_reset | output | 1 | Software reset request |
| ctl_loopback | output | 1 | Loopback enable |
| ctl_an_en | output | 1 | Negotiation enable |
| ctl_force_spd100 | output | 1 | Forced 100 Mb/s |
| ctl_force_fdx | output | 1 | Forced full duplex |
| ctl_pdown | output | 1 | Power down |
| ctl_isolate | output | 1 | Isolate |
| ctl_an_restart | output | 1 | Restart negotiation request |
| ctl_coltest | output | 1 | Collision test |
| adv_word | output | 16 | Advertisement word |
| np_word | output | 16 | Next-page word including toggle |

## Verification
The hardest situation to reach is an event that lands in the same cycle as the read that would clear its latch. To hit it, the bench raises the event input and the read strobe at the same falling edge. It then checks that this read returns the old value and that the following read still sees the bit set. The bench also proves that the sticky copies in the summary word survive repeated summary reads. It does this by interleaving summary reads with home-register reads and comparing every word against values worked out from the requirements.

// File: rtl/phy_mgmt_pkg.sv
package phy_mgmt_pkg;
    localparam int ADDR_W = 5;
    localparam int REG_W  = 16;

    localparam logic [ADDR_W-1:0] A_CTRL  = 5'h00;
    localparam logic [ADDR_W-1:0] A_STAT  = 5'h01;
    localparam logic [ADDR_W-1:0] A_ID_HI = 5'h02;
    localparam logic [ADDR_W-1:0] A_ID_LO = 5'h03;
    localparam logic [ADDR_W-1:0] A_ADV   = 5'h04;
    localparam logic [ADDR_W-1:0] A_LPAB  = 5'h05;
    localparam logic [ADDR_W-1:0] A_EXPN  = 5'h06;
    localparam logic [ADDR_W-1:0] A_NPTX  = 5'h07;
    localparam logic [ADDR_W-1:0] A_SUMM  = 5'h10;

    localparam logic [REG_W-1:0] ID_HI_VAL  = 16'h2000;
    localparam logic [REG_W-1:0] ID_LO_VAL  = {6'b010111, 6'b001010, 4'b0010};
    localparam logic [REG_W-1:0] ADV_MASK   = 16'hADFF;
    localparam logic [REG_W-1:0] ADV_RESET  = 16'h01E1;
    localparam logic [REG_W-1:0] NPTX_MASK  = 16'hB7FF;
    localparam logic [REG_W-1:0] NPTX_RESET = 16'h2001;

    typedef struct packed {
        logic             sw_rst;
        logic             loopback;
        logic             spd;
        logic             an_en;
        logic             pd;
        logic             iso;
        logic             restart;
        logic             dup;
        logic             coltest;
        logic [REG_W-1:0] adv;
        logic [REG_W-1:0] nptx;
    } ctl_state_t;
endpackage

// File: rtl/phy_sticky_bit.sv
module phy_sticky_bit #(
    parameter bit HOLD_LOW = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic sense,
    input  logic rd_home,
    output logic q
);
    logic q_d, q_q;

    generate
        if (HOLD_LOW) begin : g_low
            always_comb begin
                q_d = sense & (q_q | rd_home);
                if (clr) q_d = 1'b0;
            end
            // R7
            ll_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !sense |=> !q_q);
        end else begin : g_high
            always_comb begin
                q_d = sense | (q_q & ~rd_home);
                if (clr) q_d = 1'b0;
            end
            // R8
            lh_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (sense && !clr) |=> q_q);
            // R10
            lh_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (q_q && !rd_home && !clr) |=> q_q);
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_q <= 1'b0;
        else        q_q <= q_d;
    end

    assign q = q_q;
endmodule

// File: rtl/phy_mgmt_rdmux.sv
module phy_mgmt_rdmux
    import phy_mgmt_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  ctrl_w,
    input  logic [REG_W-1:0]  stat_w,
    input  logic [REG_W-1:0]  adv_w,
    input  logic [REG_W-1:0]  lpab_w,
    input  logic [REG_W-1:0]  expn_w,
    input  logic [REG_W-1:0]  nptx_w,
    input  logic [REG_W-1:0]  summ_w,
    output logic [REG_W-1:0]  rd_w
);
    always_comb begin
        case (addr)
            A_CTRL:  rd_w = ctrl_w;
            A_STAT:  rd_w = stat_w;
            A_ID_HI: rd_w = ID_HI_VAL;
            A_ID_LO: rd_w = ID_LO_VAL;
            A_ADV:   rd_w = adv_w;
            A_LPAB:  rd_w = lpab_w;
            A_EXPN:  rd_w = expn_w;
            A_NPTX:  rd_w = nptx_w;
            A_SUMM:  rd_w = summ_w;
            default: rd_w = '0;
        endcase
    end
endmodule

// File: rtl/phy_mgmt_regs.sv
module phy_mgmt_regs
    import phy_mgmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strap_an_en,
    input  logic              strap_speed100,
    input  logic              strap_full_duplex,
    input  logic              pwrdn_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              wr_en,
    input  logic [REG_W-1:0]  wr_data,
    input  logic              rd_en,
    output logic [REG_W-1:0]  rd_data,
    input  logic              link_ok,
    input  logic              jabber_evt,
    input  logic              rfault_evt,
    input  logic              an_done,
    input  logic              page_rx_evt,
    input  logic              spd10,
    input  logic              full_dup,
    input  logic              lp_an_able,
    input  logic [REG_W-1:0]  lp_ability,
    input  logic              tog_prev,
    input  logic              reset_done,
    input  logic              an_started,
    output logic              ctl_sw_reset,
    output logic              ctl_loopback,
    output logic              ctl_an_en,
    output logic              ctl_force_spd100,
    output logic              ctl_force_fdx,
    output logic              ctl_pdown,
    output logic              ctl_isolate,
    output logic              ctl_an_restart,
    output logic              ctl_coltest,
    output logic [REG_W-1:0]  adv_word,
    output logic [REG_W-1:0]  np_word
);
    ctl_state_t       st_d, st_q;
    logic [REG_W-1:0] rdat_d, rdat_q;

    logic rd_stat, rd_expn, wr_ctrl, wr_adv, wr_nptx, do_reset, pin_pd;
    logic link_l, jab_l, rf_l, page_l;
    logic [REG_W-1:0] ctrl_w, stat_w, expn_w, nptx_w, summ_w, mux_w;

    function automatic ctl_state_t reset_image(input logic an, input logic s100, input logic fd);
        ctl_state_t r;
        r = '0;
        r.an_en = an;
        r.spd   = s100;
        r.dup   = fd;
        r.adv   = ADV_RESET;
        r.nptx  = NPTX_RESET;
        return r;
    endfunction

    assign rd_stat  = rd_en && (reg_addr == A_STAT);
    assign rd_expn  = rd_en && (reg_addr == A_EXPN);
    assign wr_ctrl  = wr_en && (reg_addr == A_CTRL);
    assign wr_adv   = wr_en && (reg_addr == A_ADV);
    assign wr_nptx  = wr_en && (reg_addr == A_NPTX);
    assign do_reset = st_q.sw_rst && reset_done;
    assign pin_pd   = ~pwrdn_n;

    phy_sticky_bit #(.HOLD_LOW(1'b1)) link_i (
        .clk(clk), .rst_n(rst_n), .clr(do_reset),
        .sense(link_ok), .rd_home(rd_stat), .q(link_l));
    phy_sticky_bit #(.HOLD_LOW(1'b0)) jab_i (
        .clk(clk), .rst_n(rst_n), .clr(do_reset),
        .sense(jabber_evt), .rd_home(rd_stat), .q(jab_l));
    phy_sticky_bit #(.HOLD_LOW(1'b0)) rf_i (
        .clk(clk), .rst_n(rst_n), .clr(do_reset),
        .sense(rfault_evt), .rd_home(rd_stat), .q(rf_l));
    phy_sticky_bit #(.HOLD_LOW(1'b0)) page_i (
        .clk(clk), .rst_n(rst_n), .clr(do_reset),
        .sense(page_rx_evt), .rd_home(rd_expn), .q(page_l));

    always_comb begin
        ctrl_w = {st_q.sw_rst, st_q.loopback, st_q.spd, st_q.an_en, st_q.pd | pin_pd,
                  st_q.iso, st_q.restart, st_q.dup, st_q.coltest, 7'b0};
        stat_w = {1'b0, 4'b1111, 4'b0000, 1'b1, an_done, rf_l, 1'b1, link_l, jab_l, 1'b1};
        expn_w = {13'b0, 1'b1, page_l, lp_an_able};
        nptx_w = st_q.nptx | {4'b0, ~tog_prev, 11'b0};
        summ_w = {7'b0, page_l, 1'b0, rf_l, jab_l, an_done, st_q.loopback,
                  full_dup, spd10, link_l};
    end

    phy_mgmt_rdmux rdmux_i (
        .addr(reg_addr), .ctrl_w(ctrl_w), .stat_w(stat_w), .adv_w(st_q.adv),
        .lpab_w(lp_ability), .expn_w(expn_w), .nptx_w(nptx_w), .summ_w(summ_w),
        .rd_w(mux_w));

    always_comb begin
        st_d   = st_q;
        rdat_d = rdat_q;
        if (st_q.restart && an_started) st_d.restart = 1'b0;
        if (wr_ctrl) begin
            st_d.sw_rst   = st_q.sw_rst | wr_data[15];
            st_d.loopback = wr_data[14];
            st_d.spd      = wr_data[13];
            st_d.an_en    = wr_data[12];
            st_d.pd       = wr_data[11];
            st_d.iso      = wr_data[10];
            st_d.restart  = st_d.restart | (wr_data[9] & wr_data[12]);
            st_d.dup      = wr_data[8];
            st_d.coltest  = wr_data[7];
        end
        if (pin_pd)  st_d.pd   = 1'b1;
        if (wr_adv)  st_d.adv  = wr_data & ADV_MASK;
        if (wr_nptx) st_d.nptx = wr_data & NPTX_MASK;
        if (do_reset) st_d = reset_image(strap_an_en, strap_speed100, strap_full_duplex);
        if (rd_en) rdat_d = mux_w;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= reset_image(strap_an_en, strap_speed100, strap_full_duplex);
            rdat_q <= '0;
        end else begin
            st_q   <= st_d;
            rdat_q <= rdat_d;
        end
    end

    assign rd_data          = rdat_q;
    assign ctl_sw_reset     = st_q.sw_rst;
    assign ctl_loopback     = st_q.loopback;
    assign ctl_an_en        = st_q.an_en;
    assign ctl_force_spd100 = ~st_q.an_en & st_q.spd;
    assign ctl_force_fdx    = ~st_q.an_en & st_q.dup;
    assign ctl_pdown        = st_q.pd | pin_pd;
    assign ctl_isolate      = st_q.iso;
    assign ctl_an_restart   = st_q.restart;
    assign ctl_coltest      = st_q.coltest;
    assign adv_word         = st_q.adv;
    assign np_word          = nptx_w;

    // R4
    swrst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_sw_reset && !reset_done) |=> ctl_sw_reset);
    // R4
    swrst_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_sw_reset && reset_done) |=> (!ctl_sw_reset && adv_word == ADV_RESET));
    // R5
    restart_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_an_restart && !an_started && !reset_done) |=> ctl_an_restart);
    // R5
    restart_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_an_restart && !(wr_en && reg_addr == A_CTRL)) |=> !ctl_an_restart);
    // R6
    pdown_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pwrdn_n && !reset_done) |=> ctl_pdown);
endmodule

// File: tb/phy_mgmt_regs_tb_top.sv
`timescale 1ns/1ps
module phy_mgmt_regs_tb_top;
    logic clk = 1'b0, rst_n = 1'b0;
    logic pwrdn_n = 1'b1;
    logic [4:0] reg_addr = '0;
    logic wr_en = 1'b0, rd_en = 1'b0;
    logic [15:0] wr_data = '0, rd_data;
    logic link_ok = 0, jabber_evt = 0, rfault_evt = 0, an_done = 0, page_rx_evt = 0;
    logic spd10 = 0, full_dup = 0, lp_an_able = 1, tog_prev = 0, reset_done = 0, an_started = 0;
    logic [15:0] lp_ability = 16'hC5E1;
    logic ctl_sw_reset, ctl_loopback, ctl_an_en, ctl_force_spd100, ctl_force_fdx;
    logic ctl_pdown, ctl_isolate, ctl_an_restart, ctl_coltest;
    logic [15:0] adv_word, np_word;
    int errors = 0, checks = 0, cyc = 0;
    logic [15:0] v;

    always #10 clk = ~clk;

    phy_mgmt_regs dut_i (
        .clk(clk), .rst_n(rst_n), .strap_an_en(1'b1), .strap_speed100(1'b1),
        .strap_full_duplex(1'b1), .pwrdn_n(pwrdn_n), .reg_addr(reg_addr),
        .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
        .link_ok(link_ok), .jabber_evt(jabber_evt), .rfault_evt(rfault_evt),
        .an_done(an_done), .page_rx_evt(page_rx_evt), .spd10(spd10),
        .full_dup(full_dup), .lp_an_able(lp_an_able), .lp_ability(lp_ability),
        .tog_prev(tog_prev), .reset_done(reset_done), .an_started(an_started),
        .ctl_sw_reset(ctl_sw_reset), .ctl_loopback(ctl_loopback), .ctl_an_en(ctl_an_en),
        .ctl_force_spd100(ctl_force_spd100), .ctl_force_fdx(ctl_force_fdx),
        .ctl_pdown(ctl_pdown), .ctl_isolate(ctl_isolate), .ctl_an_restart(ctl_an_restart),
        .ctl_coltest(ctl_coltest), .adv_word(adv_word), .np_word(np_word));

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 50000) begin
            errors = errors + 1;
            $display("FAIL watchdog: run hung");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic do_write(input logic [4:0] a, input logic [15:0] d);
        @(negedge clk); reg_addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic do_read(input logic [4:0] a, output logic [15:0] d);
        @(negedge clk); reg_addr = a; rd_en = 1'b1;
        @(negedge clk); rd_en = 1'b0; d = rd_data;
    endtask

    task automatic pulse_evt(input int which);
        @(negedge clk);
        case (which)
            0: jabber_evt = 1'b1; 1: rfault_evt = 1'b1; 2: page_rx_evt = 1'b1;
            3: reset_done = 1'b1; 4: an_started = 1'b1; 5: pwrdn_n = 1'b0;
            default: link_ok = 1'b0;
        endcase
        @(negedge clk);
        jabber_evt = 0; rfault_evt = 0; page_rx_evt = 0; reset_done = 0;
        an_started = 0; pwrdn_n = 1; link_ok = (which == 6) ? 1'b1 : link_ok;
    endtask

    function automatic logic [15:0] exp_base(input int a);
        case (a)
            0: return 16'h3100;  1: return 16'h7849;  2: return 16'h2000;
            3: return 16'h5CA2;  4: return 16'h01E1;  5: return 16'hC5E1;
            6: return 16'h0005;  7: return 16'h2001 | 16'h0800;
            default: return 16'h0000;
        endcase
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state of outputs and read latency
        check("R1 rd_data reset", rd_data, 16'h0000);
        check("R11 an on force spd", {15'b0, ctl_force_spd100}, 16'h0);
        check("R11 an on force fdx", {15'b0, ctl_force_fdx}, 16'h0);
        check("R1 adv_word", adv_word, 16'h01E1);
        // R1 R2 sweep over all addresses
        for (int a = 0; a < 32; a++) begin
            do_read(a[4:0], v);
            check(a < 2 || a == 4 || a == 7 ? "R1 sweep" : "R2 sweep", v, exp_base(a));
        end
        // R3 R2 write all ones everywhere except control
        for (int a = 1; a < 32; a++) do_write(a[4:0], 16'hFFFF);
        for (int a = 0; a < 32; a++) begin
            do_read(a[4:0], v);
            check(a == 4 || a == 7 ? "R3 masks" : "R2 writes ignored", v,
                  a == 4 ? 16'hADFF : (a == 7 ? 16'hBFFF : exp_base(a)));
        end
        tog_prev = 1'b1;
        do_read(5'h07, v); check("R3 toggle inverse", v, 16'hB7FF);
        check("R3 np_word", np_word, 16'hB7FF);
        // R11 forced mode
        do_write(5'h00, 16'h2100);
        check("R11 forced spd", {15'b0, ctl_force_spd100}, 16'h1);
        check("R11 forced fdx", {15'b0, ctl_force_fdx}, 16'h1);
        do_write(5'h00, 16'h0000);
        check("R11 forced clear", {14'b0, ctl_force_spd100, ctl_force_fdx}, 16'h0);
        // R5 restart
        do_write(5'h00, 16'h0200);
        do_read(5'h00, v); check("R5 restart ignored with an off", v, 16'h0000);
        do_write(5'h00, 16'h1200);
        do_read(5'h00, v); check("R5 restart set", v, 16'h1200);
        do_write(5'h00, 16'h1000);
        do_read(5'h00, v); check("R5 write 0 keeps restart", v, 16'h1200);
        pulse_evt(4);
        do_read(5'h00, v); check("R5 restart cleared", v, 16'h1000);
        check("R5 ctl_an_restart", {15'b0, ctl_an_restart}, 16'h0);
        // R6 power down pin
        pulse_evt(5);
        do_read(5'h00, v); check("R6 pin sets pd", v, 16'h1800);
        do_write(5'h00, 16'h1000);
        do_read(5'h00, v); check("R6 pd cleared by write", v, 16'h1000);
        @(negedge clk); pwrdn_n = 1'b0; #1;
        check("R6 pin ORed", {15'b0, ctl_pdown}, 16'h1);
        pwrdn_n = 1'b1;
        do_write(5'h00, 16'h1000);
        // R7 link latch low
        link_ok = 1'b1;
        do_read(5'h01, v); check("R7 link not yet set", v, 16'h7849);
        do_read(5'h01, v); check("R7 link set after read", v, 16'h784D);
        pulse_evt(6);
        do_read(5'h01, v); check("R7 link fail latched", v, 16'h7849);
        do_read(5'h01, v); check("R7 link back", v, 16'h784D);
        // R8 jabber and remote fault
        pulse_evt(0);
        do_read(5'h10, v); check("R8 summary jabber", v, 16'h0021);
        do_read(5'h10, v); check("R8 summary read keeps jabber", v, 16'h0021);
        do_read(5'h01, v); check("R8 jabber in status", v, 16'h784F);
        do_read(5'h01, v); check("R8 jabber cleared", v, 16'h784D);
        do_read(5'h10, v); check("R8 summary after clear", v, 16'h0001);
        pulse_evt(1);
        do_read(5'h10, v); check("R8 summary rfault", v, 16'h0041);
        do_read(5'h01, v); check("R8 rfault in status", v, 16'h785D);
        do_read(5'h01, v); check("R8 rfault cleared", v, 16'h784D);
        // R9 page received
        pulse_evt(2);
        do_read(5'h10, v); check("R9 summary page", v, 16'h0101);
        do_read(5'h10, v); check("R9 summary read keeps page", v, 16'h0101);
        do_read(5'h06, v); check("R9 expansion page", v, 16'h0007);
        do_read(5'h06, v); check("R9 page cleared", v, 16'h0005);
        do_read(5'h10, v); check("R9 summary after clear", v, 16'h0001);
        // R10 event in same cycle as clearing read
        @(negedge clk); reg_addr = 5'h01; rd_en = 1'b1; jabber_evt = 1'b1;
        @(negedge clk); rd_en = 1'b0; jabber_evt = 1'b0; v = rd_data;
        check("R10 pre-clear value", v, 16'h784D);
        do_read(5'h01, v); check("R10 event survives read", v, 16'h784F);
        do_read(5'h01, v); check("R10 then cleared", v, 16'h784D);
        // R4 software reset
        do_write(5'h00, 16'h8000);
        do_read(5'h00, v); check("R4 reset bit reads 1", v, 16'h8000);
        check("R4 ctl_sw_reset", {15'b0, ctl_sw_reset}, 16'h1);
        do_write(5'h00, 16'h0000);
        do_read(5'h00, v); check("R4 write 0 keeps reset", v, 16'h8000);
        pulse_evt(3);
        do_read(5'h00, v); check("R4 control restored", v, 16'h3100);
        do_read(5'h04, v); check("R4 adv restored", v, 16'h01E1);
        do_read(5'h07, v); check("R4 nptx restored", v, 16'h2001);
        do_read(5'h01, v); check("R4 link latch cleared", v, 16'h7849);
        // R2 live status fields
        an_done = 1; spd10 = 1; full_dup = 1;
        do_read(5'h01, v); check("R2 status an_done", v, 16'h786D);
        do_write(5'h00, 16'h7100);
        do_read(5'h10, v); check("R2 summary fields", v, 16'h001F);
        check("R2 loopback out", {15'b0, ctl_loopback}, 16'h1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule